// File: doc/BRIEF.md
# Completion Queue Writer with Phase Bit

This block turns per-packet completion events from a transmit or receive path into 16-byte completion records and issues one memory write request per record into a ring that lives in host memory. Software never reads a hardware producer pointer. Instead, each record carries a phase bit that the writer inverts on every pass around the ring, so the host can tell a freshly written entry from one left over from the previous lap by comparing that bit with the wrap parity of its own consumer index.

A small configuration window sets the ring base address, the ring size as a power of two and an enable. While the ring is disabled, its producer position is held at zero and incoming events wait at the input instead of being lost. After record writes are accepted downstream, the block raises a one-cycle interrupt request. Bursts of records coalesce into one request until the interrupt path reports that the pending request was delivered.

Top module: `cqw_writer`

## Requirements
- R1: After reset the ring is disabled, `evt_ready`, `wr_valid` and `irq` are 0, and the base address is 0.
- R2: A configuration write to byte offset 0x0 sets the enable from bit 0 and the ring size as log2 from bits 20:16. Offset 0x8 sets base bits 31:0, with bits 3:0 forced to 0. Offset 0xC sets base bits 63:32. A write to offset 0x4 changes nothing.
- R3: `wr_data` holds four 32-bit words, with word k at bits 32k+31:32k. Word 0 is `evt_tag` zero-extended, word 1 is `evt_len` zero-extended, and word 2 is 0. Word 3 has the phase in bit 31, the ring slot in bits 15:0, and zeros elsewhere.
- R4: Each accepted event yields exactly one record, in arrival order. The producer position advances by one per record, and `wr_addr` = base + slot*16, where slot = producer position modulo the ring size.
- R5: The phase bit is 1 on the first pass through the ring (slots written before the first wrap). It is inverted on every later pass: 0 on the second pass, 1 on the third, and so on.
- R6: While the ring is disabled, `evt_ready` is 0 and no record is produced. A held event is accepted once the ring is enabled. The producer position returns to 0, so the first record after re-enabling goes to slot 0 with phase 1.
- R7: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold steady and `evt_ready` is 0.
- R8: `irq` pulses for one cycle in the cycle after a write handshake (`wr_valid` and `wr_ready` both 1) when no interrupt is pending. Further handshakes raise no pulse until `irq_done` clears the pending state. A handshake in the same cycle as `irq_done` pulses again.
- R9: With a 256-entry ring (log2 size 8), record 256 goes to slot 255 with phase 1, and record 257 goes to slot 0 with phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| evt_valid | input | 1 | Completion event present |
| evt_ready | output | 1 | Completion event accepted this cycle |
| evt_tag | input | 16 | Event identifier placed in word 0 |
| evt_len | input | 16 | Packet length in bytes placed in word 1 |
| wr_valid | output | 1 | Record write request valid |
| wr_ready | input | 1 | Downstream accepts the write request |
| wr_addr | output | 64 | Host address of the record |
| wr_data | output | 128 | Record contents, word 0 in the low bits |
| irq | output | 1 | One-cycle interrupt request |
| irq_done | input | 1 | Pending interrupt delivered |

## Verification
A table of ten events walked through a four-entry ring covers three passes. It separates correct phase inversion on each wrap from a phase that never changes or changes only once, and it confirms slot arithmetic against the base address. Events held while the ring is disabled, then released, tell stalling apart from dropping and confirm that the producer position restarts at slot 0. A downstream stall shows whether the record holds still. A run of 257 events on a 256-entry ring probes the wrap at full default size. Interrupt tests issue records with and without an intervening delivery notice, which shows whether pulses coalesce or repeat.

// File: rtl/cqw_pkg.sv
package cqw_pkg;
  localparam int LOG_W         = 5;
  localparam int REC_BYTES_LOG = 4;

  typedef struct packed {
    logic [63:0]      base;
    logic [LOG_W-1:0] log_size;
    logic             en;
  } ring_cfg_t;

  typedef struct packed {
    logic [31:0] w3;
    logic [31:0] w2;
    logic [31:0] w1;
    logic [31:0] w0;
  } cq_rec_t;

  // slot inside the ring for a producer position
  function automatic logic [31:0] ring_slot(input logic [31:0] ptr, input logic [LOG_W-1:0] lg);
    return ptr & ((32'd1 << lg) - 32'd1);
  endfunction

  // lap parity: the bit just above the slot bits
  function automatic logic wrap_bit(input logic [31:0] ptr, input logic [LOG_W-1:0] lg);
    return ptr[lg];
  endfunction

  // phase written into a record: 1 on the first lap
  function automatic logic phase_of(input logic [31:0] ptr, input logic [LOG_W-1:0] lg);
    return ~wrap_bit(ptr, lg);
  endfunction

  // advance modulo twice the ring size
  function automatic logic [31:0] ptr_next(input logic [31:0] ptr, input logic [LOG_W-1:0] lg);
    return (ptr + 32'd1) & ((32'd2 << lg) - 32'd1);
  endfunction

  function automatic logic [63:0] slot_addr(input logic [63:0] base, input logic [15:0] slot);
    return base + ({48'd0, slot} << REC_BYTES_LOG);
  endfunction
endpackage

// File: rtl/cqw_cfg_regs.sv
module cqw_cfg_regs
  import cqw_pkg::*;
#(
  parameter int MAX_LOG = 16,
  parameter int DEF_LOG = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [3:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output ring_cfg_t   cfg
);
  localparam logic [3:0] OFS_CTRL    = 4'h0;
  localparam logic [3:0] OFS_BASE_LO = 4'h8;
  localparam logic [3:0] OFS_BASE_HI = 4'hC;
  localparam int         LOG_LSB     = 16;

  logic [LOG_W-1:0] log_field;
  logic [LOG_W-1:0] log_clamped;

  assign log_field   = cfg_wdata[LOG_LSB +: LOG_W];
  assign log_clamped = (int'(log_field) > MAX_LOG) ? LOG_W'(MAX_LOG) : log_field;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.en       <= 1'b0;
      cfg.log_size <= LOG_W'(DEF_LOG);
      cfg.base     <= 64'd0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        OFS_CTRL: begin
          cfg.en       <= cfg_wdata[0];
          cfg.log_size <= log_clamped;
        end
        OFS_BASE_LO: cfg.base[31:0]  <= {cfg_wdata[31:4], 4'b0000};
        OFS_BASE_HI: cfg.base[63:32] <= cfg_wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cqw_prod_ptr.sv
module cqw_prod_ptr
  import cqw_pkg::*;
#(
  parameter int PTR_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LOG_W-1:0] log_size,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= PTR_W'(ptr_next(32'(ptr), log_size));
    end
  end
endmodule

// File: rtl/cqw_rec_stage.sv
module cqw_rec_stage
  import cqw_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  cq_rec_t      rec_in,
  input  logic [63:0]  addr_in,
  input  logic         wr_ready,
  output logic         wr_valid,
  output logic [63:0]  wr_addr,
  output logic [127:0] wr_data,
  output logic         free
);
  assign free = !wr_valid || wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= 64'd0;
      wr_data  <= 128'd0;
    end else if (load) begin
      wr_valid <= 1'b1;
      wr_addr  <= addr_in;
      wr_data  <= rec_in;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cqw_irq.sv
module cqw_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hs,
  input  logic irq_done,
  output logic irq
);
  logic pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq     <= wr_hs && (!pending || irq_done);
      pending <= wr_hs || (pending && !irq_done);
    end
  end
endmodule

// File: rtl/cqw_writer.sv
module cqw_writer
  import cqw_pkg::*;
#(
  parameter int MAX_LOG = 16,
  parameter int DEF_LOG = 8,
  parameter int TAG_W   = 16,
  parameter int LEN_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [3:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             evt_valid,
  output logic             evt_ready,
  input  logic [TAG_W-1:0] evt_tag,
  input  logic [LEN_W-1:0] evt_len,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [63:0]      wr_addr,
  output logic [127:0]     wr_data,
  output logic             irq,
  input  logic             irq_done
);
  localparam int PTR_W = MAX_LOG + 1;

  ring_cfg_t        cfg;
  logic [PTR_W-1:0] prod_ptr;
  logic             ring_en;
  logic             stage_free;
  logic             evt_take;
  logic             wr_hs;
  logic [15:0]      cur_slot;
  logic             cur_phase;
  cq_rec_t          rec;
  logic [63:0]      rec_addr;

  cqw_cfg_regs #(.MAX_LOG(MAX_LOG), .DEF_LOG(DEF_LOG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg(cfg)
  );

  assign ring_en   = cfg.en;
  assign evt_ready = ring_en && stage_free;
  assign evt_take  = evt_valid && evt_ready;
  assign wr_hs     = wr_valid && wr_ready;

  cqw_prod_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .en(ring_en), .log_size(cfg.log_size),
    .adv(evt_take), .ptr(prod_ptr)
  );

  assign cur_slot  = 16'(ring_slot(32'(prod_ptr), cfg.log_size));
  assign cur_phase = phase_of(32'(prod_ptr), cfg.log_size);
  assign rec_addr  = slot_addr(cfg.base, cur_slot);

  always_comb begin
    rec.w0 = 32'(evt_tag);
    rec.w1 = 32'(evt_len);
    rec.w2 = 32'd0;
    rec.w3 = {cur_phase, 15'd0, cur_slot};
  end

  cqw_rec_stage u_stage (
    .clk(clk), .rst_n(rst_n), .load(evt_take), .rec_in(rec), .addr_in(rec_addr),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .free(stage_free)
  );

  cqw_irq u_irq (
    .clk(clk), .rst_n(rst_n), .wr_hs(wr_hs), .irq_done(irq_done), .irq(irq)
  );
endmodule

// File: rtl/cqw_writer_chk.sv
module cqw_writer_chk #(
  parameter int PTR_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ring_en,
  input logic [PTR_W-1:0] prod_ptr,
  input logic             evt_valid,
  input logic             evt_ready,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [63:0]      wr_addr,
  input logic [127:0]     wr_data,
  input logic             irq
);
  // R6: nothing is taken while the ring is off
  a_r6_stall_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_en |-> !evt_ready);

  // R7: a stalled request holds still
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R4: every accepted event becomes a request
  a_r4_event_to_record: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready) |=> wr_valid);

  // R5: the record taken at producer position 0 has phase 1
  a_r5_first_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready && prod_ptr == '0) |=> wr_data[127]);

  // R8: an interrupt request follows a write handshake
  a_r8_irq_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(wr_valid && wr_ready));
endmodule

bind cqw_writer cqw_writer_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ring_en(ring_en), .prod_ptr(prod_ptr),
  .evt_valid(evt_valid), .evt_ready(evt_ready), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
);

// File: tb/cqw_writer_tb.sv
`timescale 1ns/1ps
module cqw_writer_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_wr = 1'b0;
  logic [3:0]   cfg_addr = 4'h0;
  logic [31:0]  cfg_wdata = 32'd0;
  logic         evt_valid = 1'b0;
  logic         evt_ready;
  logic [15:0]  evt_tag = 16'd0;
  logic [15:0]  evt_len = 16'd0;
  logic         wr_valid;
  logic         wr_ready = 1'b1;
  logic [63:0]  wr_addr;
  logic [127:0] wr_data;
  logic         irq;
  logic         irq_done = 1'b0;

  int tests = 0;
  int fails = 0;
  int irq_cnt = 0;
  bit done = 1'b0;

  localparam logic [63:0] BASE = 64'h0000_0001_0000_1000;

  // {tag, len, slot, phase} for a 4-entry ring, three laps
  localparam logic [40:0] VEC [10] = '{
    {16'h0100, 16'd60,  8'd0, 1'b1},
    {16'h0101, 16'd67,  8'd1, 1'b1},
    {16'h0102, 16'd74,  8'd2, 1'b1},
    {16'h0103, 16'd81,  8'd3, 1'b1},
    {16'h0104, 16'd88,  8'd0, 1'b0},
    {16'h0105, 16'd95,  8'd1, 1'b0},
    {16'h0106, 16'd102, 8'd2, 1'b0},
    {16'h0107, 16'd109, 8'd3, 1'b0},
    {16'h0108, 16'd1514, 8'd0, 1'b1},
    {16'h0109, 16'd64,  8'd1, 1'b1}
  };

  cqw_writer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_tag(evt_tag), .evt_len(evt_len), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq), .irq_done(irq_done)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_rec(input string req, input logic [15:0] tag, input logic [15:0] len,
                         input int slot, input logic ph);
    chk({req, " valid"}, 128'(wr_valid), 128'(1));
    chk({req, " addr"}, 128'(wr_addr), 128'(BASE + 64'(slot) * 64'd16));
    chk({req, " data"}, wr_data, {ph, 15'd0, 16'(slot), 32'd0, 16'd0, len, 16'd0, tag});
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // returns at the negedge after acceptance, with the record visible
  task automatic push(input logic [15:0] tag, input logic [15:0] len);
    evt_tag = tag; evt_len = len; evt_valid = 1'b1;
    while (!evt_ready) @(negedge clk);
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int base_irq;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 evt_ready", 128'(evt_ready), 128'(0));
    chk("R1 wr_valid", 128'(wr_valid), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", 128'(irq), 128'(0));
    chk("R1 ready after reset", 128'(evt_ready), 128'(0));

    // R6 disabled ring stalls events
    evt_valid = 1'b1; evt_tag = 16'hdead; evt_len = 16'd9;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R6 stalled ready", 128'(evt_ready), 128'(0));
      chk("R6 no record", 128'(wr_valid), 128'(0));
    end
    evt_valid = 1'b0;

    // R2 configure: low nibble of base is forced to zero, 0x4 is ignored
    cfg_write(4'h8, 32'h0000_100c);
    cfg_write(4'hC, 32'h0000_0001);
    cfg_write(4'h0, 32'h0002_0001);
    cfg_write(4'h4, 32'hffff_ffff);
    base_irq = irq_cnt;

    // R3 R4 R5 table walk over three laps
    for (int k = 0; k < 10; k++) begin
      push(VEC[k][40:25], VEC[k][24:9]);
      chk_rec($sformatf("R3 R4 R5 R2 vec%0d", k), VEC[k][40:25], VEC[k][24:9],
              int'(VEC[k][8:1]), VEC[k][0]);
    end
    repeat (3) @(negedge clk);
    chk("R8 coalesced irq count", 128'(irq_cnt - base_irq), 128'(1));
    chk("R4 idle after table", 128'(wr_valid), 128'(0));

    // R6 disable resets position, held event waits, then lands at slot 0
    cfg_write(4'h0, 32'h0002_0000);
    evt_valid = 1'b1; evt_tag = 16'h0055; evt_len = 16'd55;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 held while off", 128'(wr_valid), 128'(0));
    end
    cfg_write(4'h0, 32'h0002_0001);
    push(16'h0055, 16'd55);
    chk_rec("R6 restart slot0", 16'h0055, 16'd55, 0, 1'b1);

    // R7 downstream stall
    @(negedge clk);
    wr_ready = 1'b0;
    push(16'h0077, 16'd77);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk_rec("R7 held record", 16'h0077, 16'd77, 1, 1'b1);
      chk("R7 input blocked", 128'(evt_ready), 128'(0));
    end
    wr_ready = 1'b1;
    @(negedge clk);
    chk("R7 released", 128'(wr_valid), 128'(0));

    // R8 interrupt coalescing and re-arm
    irq_done = 1'b1;
    @(negedge clk);
    irq_done = 1'b0;
    base_irq = irq_cnt;
    push(16'h0001, 16'd1);
    push(16'h0002, 16'd2);
    repeat (3) @(negedge clk);
    chk("R8 one pulse for two records", 128'(irq_cnt - base_irq), 128'(1));
    irq_done = 1'b1;
    @(negedge clk);
    irq_done = 1'b0;
    push(16'h0003, 16'd3);
    repeat (3) @(negedge clk);
    chk("R8 re-armed pulse", 128'(irq_cnt - base_irq), 128'(2));

    // R9 256-entry ring wrap
    cfg_write(4'h0, 32'h0008_0000);
    cfg_write(4'h0, 32'h0008_0001);
    for (int k = 0; k < 257; k++) begin
      push(16'(k), 16'd100);
      if (k == 255) chk_rec("R9 last slot first lap", 16'(k), 16'd100, 255, 1'b1);
      if (k == 256) chk_rec("R9 wrap to slot0 phase0", 16'(k), 16'd100, 0, 1'b0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule